// File: doc/BRIEF.md
# Single-Cycle Subset Processor Core

This block is a 32-bit processor core that completes one instruction in every clock cycle. It supports six instructions: unsigned add, unsigned subtract, OR with an immediate, word load, word store and branch-if-equal. In one cycle, the core fetches the instruction and reads two registers. It then extends the immediate, runs the ALU, accesses data memory and computes the next program counter. The register write, the memory write and the PC update all occur on the same rising edge.

The core contains its own instruction memory and data memory. Both are word arrays read without a clock. Software loads the program through a write port, normally while reset is held. Each cycle, the core shows the register write and the memory store it is about to commit. It also has two read-only peek ports, one for the register file and one for data memory, so that final state can be inspected at the ports. None of these ports has flow control. One instruction retires on every clock after reset is released, and there is no back-pressure.

Top module: `scp_core`

## Requirements
- R1: A synchronous active-high `rst` forces the PC to 0 and clears all registers. While `rst` is high, `rf_we_o` and `dm_we_o` stay low and no register or memory write takes effect.
- R2: Opcode 000000 with funct 100001 writes R[rs]+R[rt] into R[rd]. Funct 100011 writes R[rs]-R[rt] into R[rd]. Bit fields are op[31:26], rs[25:21], rt[20:16], rd[15:11] and funct[5:0].
- R3: Opcode 001101 writes R[rs] OR zero-extended imm16[15:0] into R[rt].
- R4: Opcode 100011 loads the data word at R[rs]+sign-extended imm16 into R[rt]. The loaded word is visible on the same cycle's write port.
- R5: Opcode 101011 stores R[rt] at R[rs]+sign-extended imm16 and writes no register.
- R6: Opcode 000100 sets the next PC to PC+4+(sign-extended imm16 shifted left by 2) when R[rs]==R[rt]. Otherwise the next PC is PC+4. The instruction writes neither registers nor memory.
- R7: Register 0 always reads as zero. A write to it has no effect.
- R8: Any other opcode, or an R-type funct other than the two listed, writes nothing and advances the PC by 4.
- R9: Both memories are word-addressed by byte-address bits [N+1:2], where N is log2 of the depth. A store followed by a load at the same byte address returns the stored word.
- R10: Exactly one instruction retires per clock after reset. `pc_o` always stays word-aligned.
- R11: `peek_reg_data` and `peek_mem_data` show, without a clock, the register and data-memory word selected by `peek_reg` and `peek_mem`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| prog_we | input | 1 | Instruction memory write enable |
| prog_addr | input | IAW | Instruction word index to load |
| prog_data | input | 32 | Instruction word to load |
| pc_o | output | 32 | Address of the instruction executing this cycle |
| rf_we_o | output | 1 | Register write commits at the next edge |
| rf_waddr_o | output | 5 | Destination register index |
| rf_wdata_o | output | 32 | Write-back value |
| dm_we_o | output | 1 | Data store commits at the next edge |
| dm_addr_o | output | 32 | Data byte address (ALU result) |
| dm_wdata_o | output | 32 | Store data |
| peek_reg | input | 5 | Register index to inspect |
| peek_reg_data | output | 32 | Contents of the inspected register |
| peek_mem | input | DAW | Data-memory word index to inspect |
| peek_mem_data | output | 32 | Contents of the inspected data word |

## Verification
Each committed instruction reaches the ports in its own cycle, so a wrong register value or wrong decode appears on the write-back or store port as soon as an instruction reads that state. The failure normally shows a few instructions after the corrupting one. A wrong next-address computation shows on `pc_o` one clock later and shifts every record after it. The bench therefore compares every cycle against an instruction-level model and does not look only at the end state. The final peeks then catch stale writes to register 0, and to instructions skipped by the branch, that no later instruction happened to read.

// File: rtl/scp_pkg.sv
package scp_pkg;
  localparam int XLEN = 32;
  localparam int NREG = 32;
  localparam int RAW  = 5;

  localparam logic [5:0] OP_RTYPE = 6'b000000;
  localparam logic [5:0] OP_ORI   = 6'b001101;
  localparam logic [5:0] OP_LW    = 6'b100011;
  localparam logic [5:0] OP_SW    = 6'b101011;
  localparam logic [5:0] OP_BEQ   = 6'b000100;
  localparam logic [5:0] FN_ADDU  = 6'b100001;
  localparam logic [5:0] FN_SUBU  = 6'b100011;

  typedef enum logic [1:0] {ALU_ADD = 2'd0, ALU_SUB = 2'd1, ALU_OR = 2'd2} alu_op_e;

  typedef struct packed {
    logic    dst_is_rd;
    logic    b_is_imm;
    logic    imm_signed;
    logic    wb_from_mem;
    logic    mem_wr;
    logic    reg_wr;
    logic    is_branch;
    alu_op_e alu_op;
  } ctrl_t;
endpackage

// File: rtl/scp_decode.sv
module scp_decode
  import scp_pkg::*;
(
  input  logic [5:0] op,
  input  logic [5:0] funct,
  output ctrl_t      c
);
  always_comb begin
    c = '0;
    c.alu_op = ALU_ADD;
    unique case (op)
      OP_RTYPE: begin
        c.dst_is_rd = 1'b1;
        if (funct == FN_ADDU) begin
          c.reg_wr = 1'b1;
        end else if (funct == FN_SUBU) begin
          c.reg_wr = 1'b1;
          c.alu_op = ALU_SUB;
        end
      end
      OP_ORI: begin
        c.b_is_imm = 1'b1;
        c.reg_wr   = 1'b1;
        c.alu_op   = ALU_OR;
      end
      OP_LW: begin
        c.b_is_imm    = 1'b1;
        c.imm_signed  = 1'b1;
        c.wb_from_mem = 1'b1;
        c.reg_wr      = 1'b1;
      end
      OP_SW: begin
        c.b_is_imm   = 1'b1;
        c.imm_signed = 1'b1;
        c.mem_wr     = 1'b1;
      end
      OP_BEQ: begin
        c.imm_signed = 1'b1;
        c.is_branch  = 1'b1;
        c.alu_op     = ALU_SUB;
      end
      default: c.alu_op = ALU_ADD;
    endcase
  end
endmodule

// File: rtl/scp_alu.sv
module scp_alu
  import scp_pkg::*;
(
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  alu_op_e         op,
  output logic [XLEN-1:0] y,
  output logic            zero
);
  always_comb begin
    unique case (op)
      ALU_SUB: y = a - b;
      ALU_OR:  y = a | b;
      default: y = a + b;
    endcase
  end
  assign zero = (y == '0);
endmodule

// File: rtl/scp_regfile.sv
module scp_regfile
  import scp_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [RAW-1:0]  ra,
  input  logic [RAW-1:0]  rb,
  input  logic [RAW-1:0]  rc,
  input  logic            we,
  input  logic [RAW-1:0]  wa,
  input  logic [XLEN-1:0] wd,
  output logic [XLEN-1:0] da,
  output logic [XLEN-1:0] db,
  output logic [XLEN-1:0] dc
);
  logic [XLEN-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (we && (wa != '0)) begin
      regs[wa] <= wd;
    end
  end

  assign da = (ra == '0) ? '0 : regs[ra];
  assign db = (rb == '0) ? '0 : regs[rb];
  assign dc = (rc == '0) ? '0 : regs[rc];

  // R7
  r0_write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (we && wa == '0) |=> regs[0] == '0);

  // R2
  rf_write_lands_chk: assert property (@(posedge clk) disable iff (rst)
    (we && wa != '0) |=> regs[$past(wa)] == $past(wd));
endmodule

// File: rtl/scp_core.sv
module scp_core
  import scp_pkg::*;
#(
  parameter int IMEM_WORDS = 64,
  parameter int DMEM_WORDS = 64,
  localparam int IAW = $clog2(IMEM_WORDS),
  localparam int DAW = $clog2(DMEM_WORDS)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            prog_we,
  input  logic [IAW-1:0]  prog_addr,
  input  logic [31:0]     prog_data,
  output logic [31:0]     pc_o,
  output logic            rf_we_o,
  output logic [4:0]      rf_waddr_o,
  output logic [31:0]     rf_wdata_o,
  output logic            dm_we_o,
  output logic [31:0]     dm_addr_o,
  output logic [31:0]     dm_wdata_o,
  input  logic [4:0]      peek_reg,
  output logic [31:0]     peek_reg_data,
  input  logic [DAW-1:0]  peek_mem,
  output logic [31:0]     peek_mem_data
);
  logic [XLEN-1:0] pc, pc_plus4, br_target, instr;
  logic [XLEN-1:0] imem [IMEM_WORDS];
  logic [XLEN-1:0] dmem [DMEM_WORDS];
  logic [XLEN-1:0] bus_a, bus_b, alu_b, alu_y, imm_ext, dm_rdata, wb_data;
  logic [RAW-1:0]  wa;
  logic            alu_zero, take_br, reg_wr_eff, mem_wr_eff;
  ctrl_t           c;
  logic            unused_fields;

  // fetch
  always_ff @(posedge clk) begin
    if (prog_we) imem[prog_addr] <= prog_data;
  end
  assign instr = imem[pc[IAW+1:2]];
  assign unused_fields = ^instr[10:6];

  scp_decode u_dec (.op(instr[31:26]), .funct(instr[5:0]), .c(c));

  assign wa = c.dst_is_rd ? instr[15:11] : instr[20:16];
  assign reg_wr_eff = c.reg_wr & ~rst;
  assign mem_wr_eff = c.mem_wr & ~rst;

  scp_regfile u_rf (
    .clk(clk), .rst(rst),
    .ra(instr[25:21]), .rb(instr[20:16]), .rc(peek_reg),
    .we(reg_wr_eff), .wa(wa), .wd(wb_data),
    .da(bus_a), .db(bus_b), .dc(peek_reg_data)
  );

  assign imm_ext = c.imm_signed ? {{16{instr[15]}}, instr[15:0]} : {16'h0000, instr[15:0]};
  assign alu_b   = c.b_is_imm ? imm_ext : bus_b;

  scp_alu u_alu (.a(bus_a), .b(alu_b), .op(c.alu_op), .y(alu_y), .zero(alu_zero));

  // data memory
  always_ff @(posedge clk) begin
    if (mem_wr_eff) dmem[alu_y[DAW+1:2]] <= bus_b;
  end
  assign dm_rdata      = dmem[alu_y[DAW+1:2]];
  assign peek_mem_data = dmem[peek_mem];
  assign wb_data       = c.wb_from_mem ? dm_rdata : alu_y;

  // next address
  assign pc_plus4  = pc + 32'd4;
  assign br_target = pc_plus4 + {imm_ext[29:0], 2'b00};
  assign take_br   = c.is_branch & alu_zero;

  always_ff @(posedge clk) begin
    if (rst) pc <= '0;
    else     pc <= take_br ? br_target : pc_plus4;
  end

  assign pc_o       = pc;
  assign rf_we_o    = reg_wr_eff;
  assign rf_waddr_o = wa;
  assign rf_wdata_o = wb_data;
  assign dm_we_o    = mem_wr_eff;
  assign dm_addr_o  = alu_y;
  assign dm_wdata_o = bus_b;

  logic known_op;
  assign known_op = (instr[31:26] == OP_RTYPE && (instr[5:0] == FN_ADDU || instr[5:0] == FN_SUBU))
                 || instr[31:26] == OP_ORI || instr[31:26] == OP_LW
                 || instr[31:26] == OP_SW  || instr[31:26] == OP_BEQ;

  // R1
  reset_pc_zero_chk: assert property (@(posedge clk) rst |=> pc_o == 32'd0);

  // R1
  reset_no_write_chk: assert property (@(posedge clk) rst |-> (!rf_we_o && !dm_we_o));

  // R10
  pc_step_chk: assert property (@(posedge clk) disable iff (rst)
    !(c.is_branch && alu_zero) |=> pc_o == $past(pc_o) + 32'd4);

  // R10
  pc_aligned_chk: assert property (@(posedge clk) disable iff (rst) pc_o[1:0] == 2'b00);

  // R6
  branch_target_chk: assert property (@(posedge clk) disable iff (rst)
    (c.is_branch && alu_zero) |=>
      pc_o == $past(pc_o) + 32'd4 + {$past(imm_ext[29:0]), 2'b00});

  // R5
  store_no_wb_chk: assert property (@(posedge clk) disable iff (rst) dm_we_o |-> !rf_we_o);

  // R8
  unknown_op_nop_chk: assert property (@(posedge clk) disable iff (rst)
    !known_op |-> (!rf_we_o && !dm_we_o));
endmodule

// File: tb/scp_core_bench.sv
module scp_core_bench;
  localparam int IW = 64;
  localparam int DW = 64;
  localparam int NSTEPS = 30;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        prog_we = 1'b0;
  logic [5:0]  prog_addr = '0;
  logic [31:0] prog_data = '0;
  logic [31:0] pc_o, rf_wdata_o, dm_addr_o, dm_wdata_o, peek_reg_data, peek_mem_data;
  logic        rf_we_o, dm_we_o;
  logic [4:0]  rf_waddr_o;
  logic [4:0]  peek_reg = '0;
  logic [5:0]  peek_mem = '0;

  always #4 clk = ~clk;

  scp_core #(.IMEM_WORDS(IW), .DMEM_WORDS(DW)) u_scp_core (
    .clk(clk), .rst(rst), .prog_we(prog_we), .prog_addr(prog_addr), .prog_data(prog_data),
    .pc_o(pc_o), .rf_we_o(rf_we_o), .rf_waddr_o(rf_waddr_o), .rf_wdata_o(rf_wdata_o),
    .dm_we_o(dm_we_o), .dm_addr_o(dm_addr_o), .dm_wdata_o(dm_wdata_o),
    .peek_reg(peek_reg), .peek_reg_data(peek_reg_data),
    .peek_mem(peek_mem), .peek_mem_data(peek_mem_data)
  );

  typedef struct {
    logic [31:0] pc;
    logic        we;
    logic [4:0]  wa;
    logic [31:0] wd;
    logic        mwe;
    logic [31:0] maddr;
    logic [31:0] mwd;
    string       tag;
  } exp_t;

  exp_t        sb_q[$];
  logic [31:0] prog [IW];
  logic [31:0] mreg [32];
  logic [31:0] mdm  [DW];
  int          checks = 0;
  int          errors = 0;
  bit          done = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] enc_r(int rs, int rt, int rd, logic [5:0] fn);
    return {6'b000000, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction

  function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, logic [15:0] imm);
    return {op, 5'(rs), 5'(rt), imm};
  endfunction

  // driver: instruction-level model pushes one expected record per cycle
  task automatic run_model(int n);
    logic [31:0] mpc, npc, ins, se, ze, addr;
    logic [5:0]  op, fn;
    logic [4:0]  rs, rt, rd;
    exp_t        e;
    mpc = 0;
    for (int i = 0; i < 32; i++) mreg[i] = 0;
    for (int i = 0; i < DW; i++) mdm[i] = 0;
    for (int s = 0; s < n; s++) begin
      ins = prog[mpc[7:2]];
      op = ins[31:26]; fn = ins[5:0];
      rs = ins[25:21]; rt = ins[20:16]; rd = ins[15:11];
      se = {{16{ins[15]}}, ins[15:0]};
      ze = {16'h0000, ins[15:0]};
      e = '{pc: mpc, we: 0, wa: 0, wd: 0, mwe: 0, maddr: 0, mwd: 0, tag: "R8"};
      npc = mpc + 4;
      case (op)
        6'b000000: begin
          if (fn == 6'b100001) begin e.we = 1; e.wa = rd; e.wd = mreg[rs] + mreg[rt]; e.tag = "R2"; end
          else if (fn == 6'b100011) begin e.we = 1; e.wa = rd; e.wd = mreg[rs] - mreg[rt]; e.tag = "R2"; end
        end
        6'b001101: begin e.we = 1; e.wa = rt; e.wd = mreg[rs] | ze; e.tag = "R3"; end
        6'b100011: begin addr = mreg[rs] + se; e.we = 1; e.wa = rt; e.wd = mdm[addr[7:2]]; e.tag = "R4"; end
        6'b101011: begin
          addr = mreg[rs] + se; e.mwe = 1; e.maddr = addr; e.mwd = mreg[rt]; e.tag = "R5";
          mdm[addr[7:2]] = mreg[rt];
        end
        6'b000100: begin
          e.tag = "R6";
          if (mreg[rs] == mreg[rt]) npc = mpc + 4 + {se[29:0], 2'b00};
        end
        default: e.tag = "R8";
      endcase
      if (e.we && e.wa != 0) mreg[e.wa] = e.wd;
      sb_q.push_back(e);
      mpc = npc;
    end
  endtask

  // monitor: pops one record per retired instruction
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      #1;
      if (!rst && sb_q.size() > 0) begin
        e = sb_q.pop_front();
        chk(pc_o === e.pc, "R10", "pc", pc_o, e.pc);
        chk(rf_we_o === e.we, e.tag, "reg write enable", 32'(rf_we_o), 32'(e.we));
        if (e.we) begin
          chk(rf_waddr_o === e.wa, e.tag, "dest index", 32'(rf_waddr_o), 32'(e.wa));
          chk(rf_wdata_o === e.wd, e.tag, "write-back data", rf_wdata_o, e.wd);
        end
        chk(dm_we_o === e.mwe, e.tag, "store enable", 32'(dm_we_o), 32'(e.mwe));
        if (e.mwe) begin
          chk(dm_addr_o === e.maddr, e.tag, "store address", dm_addr_o, e.maddr);
          chk(dm_wdata_o === e.mwd, e.tag, "store data", dm_wdata_o, e.mwd);
        end
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #200000;
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
    finish_run();
  end

  initial begin
    for (int i = 0; i < IW; i++) prog[i] = 32'h0;
    prog[0]  = enc_i(6'b001101, 0, 1, 16'h0005);      // ori  r1 = 5
    prog[1]  = enc_i(6'b001101, 0, 2, 16'h0003);      // ori  r2 = 3
    prog[2]  = enc_r(1, 2, 3, 6'b100001);              // addu r3 = 8
    prog[3]  = enc_r(2, 1, 4, 6'b100011);              // subu r4 = -2
    prog[4]  = enc_i(6'b001101, 0, 5, 16'h0020);      // ori  r5 = 0x20
    prog[5]  = enc_i(6'b101011, 0, 3, 16'h0004);      // sw   r3 -> 0x04
    prog[6]  = enc_i(6'b101011, 5, 4, 16'hFFFC);      // sw   r4 -> 0x1C (negative offset)
    prog[7]  = enc_i(6'b100011, 5, 6, 16'hFFFC);      // lw   r6 <- 0x1C
    prog[8]  = enc_i(6'b100011, 0, 7, 16'h0004);      // lw   r7 <- 0x04
    prog[9]  = enc_i(6'b000100, 3, 7, 16'h0002);      // beq  taken -> word 12
    prog[10] = enc_i(6'b001101, 0, 8, 16'hDEAD);      // skipped
    prog[11] = enc_i(6'b001101, 0, 8, 16'hBEEF);      // skipped
    prog[12] = enc_i(6'b000100, 1, 2, 16'h0005);      // beq  not taken
    prog[13] = enc_r(1, 1, 0, 6'b100001);              // addu into r0
    prog[14] = enc_i(6'b111111, 1, 9, 16'h1234);      // unknown opcode
    prog[15] = enc_r(1, 2, 9, 6'b100000);              // unknown funct
    prog[16] = enc_i(6'b001101, 0, 9, 16'h8000);      // ori  zero-extends
    prog[17] = enc_i(6'b000100, 0, 0, 16'hFFFF);      // beq  backward to itself

    repeat (2) @(negedge clk);
    for (int i = 0; i < 18; i++) begin
      prog_we = 1'b1; prog_addr = 6'(i); prog_data = prog[i];
      @(negedge clk);
    end
    prog_we = 1'b0;
    @(negedge clk);
    #1;
    // R1 reset state
    chk(pc_o === 32'd0, "R1", "pc in reset", pc_o, 32'd0);
    chk(rf_we_o === 1'b0, "R1", "reg write in reset", 32'(rf_we_o), 32'd0);
    chk(dm_we_o === 1'b0, "R1", "store in reset", 32'(dm_we_o), 32'd0);
    peek_reg = 5'd1; #1;
    chk(peek_reg_data === 32'd0, "R1", "r1 cleared", peek_reg_data, 32'd0);

    run_model(NSTEPS);
    @(negedge clk);
    rst = 1'b0;
    wait (sb_q.size() == 0);
    @(negedge clk);
    #2;
    // R11 final register peeks against the model
    for (int r = 0; r < 10; r++) begin
      peek_reg = 5'(r); #1;
      chk(peek_reg_data === mreg[r], "R11", $sformatf("reg %0d", r), peek_reg_data, mreg[r]);
    end
    peek_reg = 5'd0; #1;
    chk(peek_reg_data === 32'd0, "R7", "r0 after write", peek_reg_data, 32'd0);
    peek_reg = 5'd8; #1;
    chk(peek_reg_data === 32'd0, "R6", "skipped instruction left r8", peek_reg_data, 32'd0);
    peek_reg = 5'd9; #1;
    chk(peek_reg_data === 32'h0000_8000, "R3", "ori zero extension", peek_reg_data, 32'h0000_8000);
    peek_mem = 6'd1; #1;
    chk(peek_mem_data === 32'd8, "R9", "word 1", peek_mem_data, 32'd8);
    peek_mem = 6'd7; #1;
    chk(peek_mem_data === 32'hFFFF_FFFE, "R9", "word 7", peek_mem_data, 32'hFFFF_FFFE);
    chk(pc_o === 32'd68, "R6", "parked on backward branch", pc_o, 32'd68);

    // R1 reset again mid-run
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    #1;
    chk(pc_o === 32'd0, "R1", "pc after second reset", pc_o, 32'd0);
    peek_reg = 5'd3; #1;
    chk(peek_reg_data === 32'd0, "R1", "r3 cleared by reset", peek_reg_data, 32'd0);
    finish_run();
  end
endmodule